// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block connects a single-cycle request port inside a synchronous design to an external asynchronous static RAM of 512K words by 16 bits. A request carries a read/write flag, a 19-bit word address, 16 bits of write data and a 2-bit lane mask. Bit 0 of the mask selects the low byte (data bits 7..0) and bit 1 selects the high byte (data bits 15..8). The controller answers each request with a one-cycle done pulse. For a read, the data arrives on the cycle of that pulse.

On the memory side the controller drives the active-low chip select, read strobe, write strobe and two byte-lane strobes, together with the address. It shares one bidirectional 16-bit data bus with the memory. The time the strobes stay low is a whole number of clock cycles, derived from the memory access time and the clock period given as parameters. The address and lane strobes settle one cycle before the write strobe falls and stay one cycle after it rises. The controller drives the data bus only while the write strobe is low, so after a read the memory always has spare cycles to release the bus.

A request with an empty lane mask completes at once and causes no bus activity. Requests that arrive while an access is in progress are dropped, so the user waits for done before issuing the next request.

Top module: `sram_bus_ctrl`

## Requirements
- R1: After reset and whenever no access is in progress, sram_ce_n, sram_oe_n and sram_we_n are 1, sram_be_n is 2'b11, rsp_done is 0, and rsp_rdata is 0 until the first read completes.
- R2: A write with a non-empty mask, sampled at clock edge k, pulls sram_ce_n low from edge k to edge k+ACC+2. It pulls sram_we_n low from edge k+1 to edge k+ACC+1. sram_addr and sram_be_n hold the request's values throughout. rsp_done goes high at edge k+ACC+2.
- R3: While an access is active, sram_be_n[0] is low exactly when mask bit 0 is set and sram_be_n[1] exactly when mask bit 1 is set. A write stores only the lanes that are enabled.
- R4: A read with a non-empty mask, sampled at edge k, holds sram_ce_n and sram_oe_n low, with sram_we_n high, from edge k to edge k+ACC. At that edge rsp_done rises and rsp_rdata holds the data that was on the bus during the last cycle of the window.
- R5: Read data lanes whose mask bit is clear are returned as zero.
- R6: The controller drives sram_dq only while sram_we_n is low, and it drives the request's write data there.
- R7: A request with mask 2'b00 raises rsp_done at the next edge, leaves all strobes high and leaves rsp_rdata unchanged.
- R8: A request that arrives while an access is in progress is ignored. It produces no bus cycle and no done pulse, and the memory is unchanged.
- R9: ACC equals ACCESS_NS divided by CLK_NS, rounded up (5 for 45 ns at 10 ns), with a minimum of 1.
- R10: rsp_done is high for a single cycle per accepted access. rsp_rdata keeps its value until the next read with a non-empty mask completes.
- R11: When a write immediately follows a read, at least one full cycle with sram_oe_n high and sram_we_n high separates the last read-strobe cycle from the first cycle in which the controller drives data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Request strobe, one cycle |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Lane mask, bit 0 low byte, bit 1 high byte |
| rsp_rdata | output | 16 | Read data |
| rsp_done | output | 1 | One-cycle completion pulse |
| sram_addr | output | 19 | Memory address |
| sram_dq | inout | 16 | Shared memory data bus |
| sram_ce_n | output | 1 | Chip select, active low |
| sram_oe_n | output | 1 | Read strobe, active low |
| sram_we_n | output | 1 | Write strobe, active low |
| sram_be_n | output | 2 | Lane strobes, active low, bit 0 low byte |

## Verification
Done is due ACC+2 edges after a write is sampled, ACC edges after a read, and one edge after an empty-mask request. The bench drives a request at a falling edge and then counts falling edges, so these results show up at counts ACC+3, ACC+1 and 1. During that count the bench samples the strobes, the address and the lane strobes at every falling edge. It tallies how many cycles each strobe is low and checks the tallies against ACC. It compares read data only at the count where done is seen. After a dropped request the bench keeps watching for ACC+4 further cycles for any stray bus cycle.

// File: rtl/sram_ctl_pkg.sv
`timescale 1ns/1ps
package sram_ctl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WSETUP,
    ST_WPULSE,
    ST_WHOLD,
    ST_READ
  } seq_state_e;

  // Whole clock cycles covering a time in ns, never below one.
  function automatic int unsigned cycles_for(input int unsigned t_ns, input int unsigned clk_ns);
    int unsigned c;
    c = (t_ns + clk_ns - 1) / clk_ns;
    return (c == 0) ? 1 : c;
  endfunction

endpackage

// File: rtl/sram_access_seq.sv
`timescale 1ns/1ps
module sram_access_seq
  import sram_ctl_pkg::*;
#(
  parameter int unsigned ACC_CYC = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  input  logic wr_i,
  input  logic any_lane_i,
  output logic accept_o,
  output logic finish_o,
  output logic capture_o,
  output logic ce_n_o,
  output logic oe_n_o,
  output logic we_n_o,
  output logic drive_o,
  output logic done_o
);

  localparam int unsigned CNT_W = (ACC_CYC < 2) ? 1 : $clog2(ACC_CYC);
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(ACC_CYC - 1);

  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             idle, last, skip;
  logic             ce_n_q, oe_n_q, we_n_q, drive_q, done_q;

  assign idle      = (state_q == ST_IDLE);
  assign last      = (cnt_q == '0);
  assign accept_o  = idle & req_i & any_lane_i;
  assign skip      = idle & req_i & ~any_lane_i;
  assign finish_o  = (state_q == ST_WHOLD) | ((state_q == ST_READ) & last);
  assign capture_o = (state_q == ST_READ) & last;
  assign cnt_en    = accept_o | (state_q == ST_WSETUP) | (state_q == ST_WPULSE) | (state_q == ST_READ);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    case (state_q)
      ST_IDLE: begin
        if (accept_o) begin
          if (wr_i) begin
            state_d = ST_WSETUP;
          end else begin
            state_d = ST_READ;
            cnt_d   = CNT_TOP;
          end
        end
      end
      ST_WSETUP: begin
        state_d = ST_WPULSE;
        cnt_d   = CNT_TOP;
      end
      ST_WPULSE: begin
        if (last) state_d = ST_WHOLD;
        else      cnt_d   = cnt_q - 1'b1;
      end
      ST_WHOLD: state_d = ST_IDLE;
      ST_READ: begin
        if (last) state_d = ST_IDLE;
        else      cnt_d   = cnt_q - 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ce_n_q  <= 1'b1;
      oe_n_q  <= 1'b1;
      we_n_q  <= 1'b1;
      drive_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      ce_n_q  <= (state_d == ST_IDLE);
      oe_n_q  <= (state_d != ST_READ);
      we_n_q  <= (state_d != ST_WPULSE);
      drive_q <= (state_d == ST_WPULSE);
      done_q  <= finish_o | skip;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign ce_n_o  = ce_n_q;
  assign oe_n_o  = oe_n_q;
  assign we_n_o  = we_n_q;
  assign drive_o = drive_q;
  assign done_o  = done_q;

  // R1: idle state keeps every strobe released
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |-> (ce_n_q && oe_n_q && we_n_q && !drive_q));

  // R2: select settled one cycle before write strobe falls
  a_r2_setup_before_we: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(we_n_q) |-> ($past(!ce_n_q) && $past(oe_n_q)));

  // R2: select still held in the cycle after write strobe rises
  a_r2_hold_after_we: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_n_q) |-> !ce_n_q);

  // R4: read strobe only with select low and write strobe high
  a_r4_read_we_high: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n_q |-> (we_n_q && !ce_n_q));

  // R7: empty-mask request completes next edge with no bus cycle
  a_r7_skip_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    skip |=> (done_q && ce_n_q));

endmodule

// File: rtl/sram_lane_path.sv
`timescale 1ns/1ps
module sram_lane_path #(
  parameter int unsigned ADDR_W = 19,
  parameter int unsigned LANES  = 2,
  parameter int unsigned LANE_W = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      accept_i,
  input  logic                      finish_i,
  input  logic                      capture_i,
  input  logic                      ce_n_i,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [LANES*LANE_W-1:0]   wdata_i,
  input  logic [LANES-1:0]          mask_i,
  input  logic [LANES*LANE_W-1:0]   dq_i,
  output logic [ADDR_W-1:0]         addr_o,
  output logic [LANES*LANE_W-1:0]   wdata_o,
  output logic [LANES-1:0]          be_n_o,
  output logic [LANES*LANE_W-1:0]   rdata_o
);

  localparam int unsigned DATA_W = LANES * LANE_W;

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [LANES-1:0]  mask_q;
  logic [LANES-1:0]  be_n_q, be_n_d;
  logic              be_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      mask_q  <= '0;
    end else if (accept_i) begin
      addr_q  <= addr_i;
      wdata_q <= wdata_i;
      mask_q  <= mask_i;
    end
  end

  assign be_en  = accept_i | finish_i;
  assign be_n_d = accept_i ? ~mask_i : '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     be_n_q <= '1;
    else if (be_en) be_n_q <= be_n_d;
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] lane_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         lane_q <= '0;
      else if (capture_i) lane_q <= mask_q[l] ? dq_i[l*LANE_W +: LANE_W] : '0;
    end
    assign rdata_o[l*LANE_W +: LANE_W] = lane_q;
  end

  assign addr_o  = addr_q;
  assign wdata_o = wdata_q;
  assign be_n_o  = be_n_q;

  // R2: address and lane strobes steady while select stays low
  a_r2_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n_i && $past(!ce_n_i)) |-> ($stable(addr_q) && $stable(be_n_q)));

  // R3: lane strobes released whenever the chip is deselected
  a_r3_be_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n_i |-> (be_n_q == '1));

  // R3: an active access always enables at least one lane
  a_r3_be_active: assert property (@(posedge clk) disable iff (!rst_n)
    !ce_n_i |-> (be_n_q != '1));

endmodule

// File: rtl/sram_bus_ctrl.sv
`timescale 1ns/1ps
module sram_bus_ctrl
  import sram_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W    = 19,
  parameter int unsigned LANES     = 2,
  parameter int unsigned LANE_W    = 8,
  parameter int unsigned ACCESS_NS = 45,
  parameter int unsigned CLK_NS    = 10
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req,
  input  logic                    req_wr,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic [LANES*LANE_W-1:0] req_wdata,
  input  logic [LANES-1:0]        req_mask,
  output logic [LANES*LANE_W-1:0] rsp_rdata,
  output logic                    rsp_done,
  output logic [ADDR_W-1:0]       sram_addr,
  inout  wire  [LANES*LANE_W-1:0] sram_dq,
  output logic                    sram_ce_n,
  output logic                    sram_oe_n,
  output logic                    sram_we_n,
  output logic [LANES-1:0]        sram_be_n
);

  localparam int unsigned DATA_W  = LANES * LANE_W;
  localparam int unsigned ACC_CYC = cycles_for(ACCESS_NS, CLK_NS);  // R9

  logic              accept, finish, capture, drive;
  logic [DATA_W-1:0] wdata;

  sram_access_seq #(.ACC_CYC(ACC_CYC)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_i      (req),
    .wr_i       (req_wr),
    .any_lane_i (|req_mask),
    .accept_o   (accept),
    .finish_o   (finish),
    .capture_o  (capture),
    .ce_n_o     (sram_ce_n),
    .oe_n_o     (sram_oe_n),
    .we_n_o     (sram_we_n),
    .drive_o    (drive),
    .done_o     (rsp_done)
  );

  sram_lane_path #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_lanes (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept_i  (accept),
    .finish_i  (finish),
    .capture_i (capture),
    .ce_n_i    (sram_ce_n),
    .addr_i    (req_addr),
    .wdata_i   (req_wdata),
    .mask_i    (req_mask),
    .dq_i      (sram_dq),
    .addr_o    (sram_addr),
    .wdata_o   (wdata),
    .be_n_o    (sram_be_n),
    .rdata_o   (rsp_rdata)
  );

  assign sram_dq = drive ? wdata : {DATA_W{1'bz}};

  // R11: drive starts only after the read strobe was high a full cycle
  a_r11_turnaround: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drive) |-> ($past(sram_oe_n) && sram_oe_n));

  // R6: bus driven only inside the write strobe window
  a_r6_drive_in_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    drive |-> (!sram_we_n && !sram_ce_n));

endmodule

// File: tb/tb_sram_bus_ctrl.sv
`timescale 1ns/1ps
module tb_sram_bus_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int ACC        = (45 + CLK_PERIOD - 1) / CLK_PERIOD;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req, req_wr;
  logic [18:0] req_addr;
  logic [15:0] req_wdata;
  logic [1:0]  req_mask;
  logic [15:0] rsp_rdata;
  logic        rsp_done;
  logic [18:0] sram_addr;
  wire  [15:0] sram_dq;
  logic        sram_ce_n, sram_oe_n, sram_we_n;
  logic [1:0]  sram_be_n;

  int total = 0;
  int fails = 0;
  bit done_run = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sram_bus_ctrl #(.ACCESS_NS(45), .CLK_NS(CLK_PERIOD)) dut (
    .clk(clk), .rst_n(rst_n), .req(req), .req_wr(req_wr), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_mask(req_mask), .rsp_rdata(rsp_rdata),
    .rsp_done(rsp_done), .sram_addr(sram_addr), .sram_dq(sram_dq),
    .sram_ce_n(sram_ce_n), .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n),
    .sram_be_n(sram_be_n)
  );

  // Memory model
  logic [15:0] model_mem [bit [18:0]];
  logic [15:0] shadow    [bit [18:0]];
  logic [15:0] rd_word;
  logic        rd_on;

  function automatic logic [15:0] model_read(input bit [18:0] a);
    return model_mem.exists(a) ? model_mem[a] : 16'h0000;
  endfunction

  function automatic logic [15:0] shadow_read(input bit [18:0] a);
    return shadow.exists(a) ? shadow[a] : 16'h0000;
  endfunction

  function automatic logic [15:0] lane_mask(input logic [1:0] m);
    return {{8{m[1]}}, {8{m[0]}}};
  endfunction

  function automatic int exp_count(input bit wr, input logic [1:0] m);
    if (m == 2'b00) return 1;
    return wr ? ACC + 3 : ACC + 1;
  endfunction

  assign rd_on = !sram_ce_n && !sram_oe_n && sram_we_n;
  assign sram_dq[7:0]  = (rd_on && !sram_be_n[0]) ? rd_word[7:0]  : 8'bz;
  assign sram_dq[15:8] = (rd_on && !sram_be_n[1]) ? rd_word[15:8] : 8'bz;

  always @(negedge clk) begin
    logic [15:0] w;
    if (rst_n && !sram_ce_n && !sram_we_n) begin
      w = model_read(sram_addr);
      if (!sram_be_n[0]) w[7:0]  = sram_dq[7:0];
      if (!sram_be_n[1]) w[15:8] = sram_dq[15:8];
      model_mem[sram_addr] = w;
    end
    rd_word = model_read(sram_addr);
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // R11 monitor: gap from last read-strobe cycle to first write-strobe cycle
  int cyc = 0;
  int last_oe = -100;
  logic prev_we = 1'b1;
  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (!sram_oe_n) last_oe = cyc;
      if (!sram_we_n && prev_we && last_oe > 0)
        chk((cyc - last_oe) >= 2, "R11 read-to-write gap", cyc - last_oe, 2);
      prev_we = sram_we_n;
    end
  end

  logic [15:0] last_rdata = 16'h0;

  // Caller is positioned at a falling edge.
  task automatic do_req(input bit wr, input logic [18:0] a, input logic [15:0] d,
                        input logic [1:0] m, input bit poke);
    int cnt = 0, lat = 0, ce_lo = 0, we_lo = 0, oe_lo = 0, bad_addr = 0, bad_be = 0, bad_dq = 0;
    req = 1'b1; req_wr = wr; req_addr = a; req_wdata = d; req_mask = m;
    while (lat == 0 && cnt < 60) begin
      @(negedge clk);
      cnt++;
      if (!sram_ce_n) begin
        ce_lo++;
        if (sram_addr != a) bad_addr++;
        if (sram_be_n != ~m) bad_be++;
      end
      if (!sram_we_n) begin
        we_lo++;
        if ((sram_dq & lane_mask(m)) != (d & lane_mask(m))) bad_dq++;
      end
      if (!sram_oe_n) oe_lo++;
      if (rsp_done) lat = cnt;
      if (poke && cnt == 2) begin
        req = 1'b1; req_wr = 1'b1; req_addr = a ^ 19'h1; req_wdata = ~d; req_mask = 2'b11;
      end else begin
        req = 1'b0;
      end
    end
    chk(lat == exp_count(wr, m), wr ? "R2 write done latency" : (m == 0 ? "R7 empty done latency" : "R4 read done latency"),
        lat, exp_count(wr, m));
    if (m == 2'b00) begin
      chk(ce_lo + we_lo + oe_lo == 0, "R7 no strobe activity", ce_lo + we_lo + oe_lo, 0);
      chk(rsp_rdata == last_rdata, "R7 read data unchanged", rsp_rdata, last_rdata);
    end else if (wr) begin
      chk(ce_lo == ACC + 2 && oe_lo == 0, "R2 select window", ce_lo, ACC + 2);
      chk(we_lo == ACC, "R9 write strobe cycles", we_lo, ACC);
      chk(bad_dq == 0, "R6 write data on bus", bad_dq, 0);
    end else begin
      chk(ce_lo == ACC && oe_lo == ACC && we_lo == 0, "R4 read strobe window", oe_lo, ACC);
    end
    if (m != 2'b00) begin
      chk(bad_addr == 0, "R2 address held", bad_addr, 0);
      chk(bad_be == 0, "R3 lane strobes", bad_be, 0);
    end
    if (wr && m != 2'b00) begin
      logic [15:0] s;
      s = shadow_read(a);
      s = (s & ~lane_mask(m)) | (d & lane_mask(m));
      shadow[a] = s;
    end
    if (!wr && m != 2'b00) begin
      chk(rsp_rdata == (shadow_read(a) & lane_mask(m)), "R4 R5 read data",
          rsp_rdata, shadow_read(a) & lane_mask(m));
      last_rdata = rsp_rdata;
    end
    if (poke) begin
      int stray = 0;
      for (int i = 0; i < ACC + 4; i++) begin
        @(negedge clk);
        if (!sram_ce_n || rsp_done) stray++;
      end
      chk(stray == 0, "R8 busy request ignored", stray, 0);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done_run) begin
      total++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [18:0] pool [8];
    pool[0] = 19'h00000; pool[1] = 19'h7FFFF; pool[2] = 19'h12345; pool[3] = 19'h00001;
    pool[4] = 19'h40000; pool[5] = 19'h2AAAA; pool[6] = 19'h55555; pool[7] = 19'h3FFFF;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; req = 1'b0; req_wr = 1'b0; req_addr = '0; req_wdata = '0; req_mask = '0;
    repeat (3) @(negedge clk);
    chk(sram_ce_n && sram_oe_n && sram_we_n, "R1 strobes in reset", {sram_ce_n, sram_oe_n, sram_we_n}, 3'b111);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sram_be_n == 2'b11 && !rsp_done, "R1 idle lane strobes", {sram_be_n, rsp_done}, 3'b110);
    chk(rsp_rdata == 16'h0, "R1 read data after reset", rsp_rdata, 0);

    // R2 R4: full word at top address
    do_req(1, 19'h7FFFF, 16'hA5C3, 2'b11, 0);
    @(negedge clk);
    chk(!rsp_done, "R10 done single cycle", rsp_done, 0);
    do_req(0, 19'h7FFFF, 16'h0, 2'b11, 0);
    // R3: upper lane only at address zero
    do_req(1, 19'h00000, 16'h1234, 2'b10, 0);
    do_req(0, 19'h00000, 16'h0, 2'b11, 0);
    chk(model_read(19'h0) == 16'h1200, "R3 only upper lane stored", model_read(19'h0), 16'h1200);
    // R5: partial-lane reads
    do_req(0, 19'h7FFFF, 16'h0, 2'b01, 0);
    do_req(0, 19'h7FFFF, 16'h0, 2'b10, 0);
    // R7: empty masks
    do_req(1, 19'h7FFFF, 16'hFFFF, 2'b00, 0);
    do_req(0, 19'h7FFFF, 16'h0, 2'b00, 0);
    chk(model_read(19'h7FFFF) == 16'hA5C3, "R7 memory unchanged", model_read(19'h7FFFF), 16'hA5C3);
    // R8: request during a write
    do_req(1, 19'h12344, 16'h5A5A, 2'b11, 1);
    do_req(0, 19'h12345, 16'h0, 2'b11, 0);
    chk(rsp_rdata == 16'h0, "R8 poked address untouched", rsp_rdata, 0);
    // R10: read data held across a write
    do_req(1, 19'h00001, 16'hBEEF, 2'b11, 0);
    chk(rsp_rdata == last_rdata, "R10 read data held", rsp_rdata, last_rdata);
    // R11: read immediately followed by a write
    do_req(0, 19'h00001, 16'h0, 2'b11, 0);
    do_req(1, 19'h00001, 16'hCAFE, 2'b01, 0);
    do_req(0, 19'h00001, 16'h0, 2'b11, 0);

    // Random mix
    for (int n = 0; n < 200; n++) begin
      bit          w;
      logic [1:0]  m;
      logic [15:0] d;
      w = 1'($urandom % 2);
      m = 2'($urandom % 4);
      d = 16'($urandom);
      do_req(w, pool[$urandom % 8], d, m, 0);
      if (($urandom % 4) == 0) @(negedge clk);
    end

    done_run = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule